// File: doc/BRIEF.md
# Latency-Scheduled Writeback Queue

This block lets a stream of instructions whose results take different fixed numbers of steps retire their results into a register file at the right moment. It is a small circular array of result slots. Each executing step takes the value waiting in the current head slot and writes it to the destination register named by that step. It then empties the head slot and moves the head on by one. Last, it places the step's own result the right number of slots ahead, so the result comes back out exactly as many steps later as its latency says.

A sequencer drives one step per strobe. Each step carries a kind code, a result value, a latency and a destination index. The block drives a one-entry register-file write port and two single-cycle indications: a bad latency, and the end of a run. The functional units that compute results are outside the block. The destination written in a step is the one named by that step, not the one that produced the value. Because a slot is emptied when it is read, a step that finds no result waiting writes zero.

Top module: `wbq_sched`

## Requirements
- R1: While `rst` is high, all slots are cleared, the head returns to slot 0 and `rf_we`, `lat_err` and `run_done` are low. The first steps after reset therefore write 0.
- R2: A step with `step_kind` 2'b00 (compute), 2'b01 (no-op) or 2'b11 (acts as no-op) and a nonzero `dest_idx` raises `rf_we` for the one cycle after its strobe edge. In that cycle `rf_waddr` equals `dest_idx` and `rf_wdata` equals the head slot's value.
- R3: A step whose `dest_idx` is 0 raises no write, but it still consumes the head slot and advances the head.
- R4: A compute step with latency L in 1..DEPTH inserts its result at (head + L) mod DEPTH, counted from the head before the step. The value is written out by the L-th consuming step after it, counting that step as the first.
- R5: The slot read by a consuming step is zeroed, so a later step that lands on it with nothing newly inserted writes 0.
- R6: A no-op step (2'b01 or 2'b11) inserts nothing, but it consumes the head and advances it like a compute step.
- R7: A step with `step_kind` 2'b10 (end of run) neither reads, clears nor advances the queue. It raises no write and raises `run_done` for one cycle.
- R8: A compute step with latency 0 or above DEPTH raises `lat_err` for one cycle and inserts nothing. It still consumes and advances.
- R9: With latency DEPTH, the result goes into the slot just consumed by the same step, and the insertion takes priority over the clearing.
- R10: Cycles with `step_valid` low change neither the queue nor the head, and raise none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Issue strobe, one step per high cycle |
| step_kind | input | 2 | 00 compute, 01 no-op, 10 end of run, 11 no-op |
| res_data | input | DATA_W | Result value of a compute step |
| res_lat | input | LAT_W | Latency of the result in steps |
| dest_idx | input | IDX_W | Destination register of this step |
| rf_we | output | 1 | Register-file write enable (registered) |
| rf_waddr | output | IDX_W | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |
| lat_err | output | 1 | One-cycle flag for a bad latency on a compute step |
| run_done | output | 1 | One-cycle flag for an end-of-run step |

## Verification
The bench builds the block with DEPTH 7, DATA_W 32, IDX_W 7 and LAT_W 4. The 4-bit latency field lets both latency 0 and latencies 8 to 15 reach the error path. A depth of 7 makes the head wrap every seven consuming steps, so latency-7 inserts into the just-freed slot and insert positions that wrap past the end are exercised many times. A long pseudo-random stream mixes every step kind, zero destinations, idle gaps and bad latencies. This stream keeps several results in flight at once.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
  typedef enum logic [1:0] {
    STEP_OP  = 2'b00,
    STEP_NOP = 2'b01,
    STEP_END = 2'b10,
    STEP_RSV = 2'b11
  } step_kind_e;
endpackage

// File: rtl/wbq_head_ptr.sv
module wbq_head_ptr #(
  parameter int DEPTH = 7,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] head
);
  logic [PW-1:0] head_nx;

  always_comb begin
    if (head == PW'(DEPTH - 1)) head_nx = '0;
    else                        head_nx = head + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)      head <= '0;
    else if (adv) head <= head_nx;
  end

  // R1: the head never leaves the slot range
  p_head_range_r1: assert property (@(posedge clk) disable iff (rst)
    head < PW'(DEPTH));

  // R1: reset puts the head on slot 0
  p_head_reset_r1: assert property (@(posedge clk)
    rst |=> head == '0);
endmodule

// File: rtl/wbq_lat_check.sv
module wbq_lat_check #(
  parameter int DEPTH = 7,
  parameter int LAT_W = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int SW = ((PW > LAT_W) ? PW : LAT_W) + 1
) (
  input  logic [PW-1:0]    head,
  input  logic [LAT_W-1:0] lat,
  output logic             lat_ok,
  output logic [PW-1:0]    ins_idx
);
  logic [SW-1:0] sum;

  always_comb begin
    lat_ok = (lat != '0) && (SW'(lat) <= SW'(DEPTH));
    sum    = SW'(head) + SW'(lat);
    if (sum >= SW'(DEPTH)) ins_idx = PW'(sum - SW'(DEPTH));
    else                   ins_idx = PW'(sum);
  end

  // R4: an accepted latency always maps inside the slot range
  always_comb begin
    if (lat_ok) a_idx_range_r4: assert (ins_idx < PW'(DEPTH) || $isunknown(head));
  end
endmodule

// File: rtl/wbq_slots.sv
module wbq_slots #(
  parameter int DEPTH  = 7,
  parameter int DATA_W = 32,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              consume,
  input  logic [PW-1:0]     head,
  input  logic              ins_en,
  input  logic [PW-1:0]     ins_idx,
  input  logic [DATA_W-1:0] ins_data,
  output logic [DATA_W-1:0] head_data
);
  logic [DEPTH-1:0][DATA_W-1:0] slot_vec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)
        q <= '0;
      else if (ins_en && ins_idx == PW'(i))
        q <= ins_data;
      else if (consume && head == PW'(i))
        q <= '0;
    end
    assign slot_vec[i] = q;
  end

  assign head_data = slot_vec[head];

  // R5: a consumed slot holds zero afterwards unless this step refilled it
  p_clear_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    consume && !(ins_en && ins_idx == head) |=> slot_vec[$past(head)] == '0);

  // R9: an insert wins over the clear of the same slot
  p_insert_wins_r9: assert property (@(posedge clk) disable iff (rst)
    ins_en |=> slot_vec[$past(ins_idx)] == $past(ins_data));
endmodule

// File: rtl/wbq_sched.sv
module wbq_sched #(
  parameter int DEPTH  = 7,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 7,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_valid,
  input  logic [1:0]        step_kind,
  input  logic [DATA_W-1:0] res_data,
  input  logic [LAT_W-1:0]  res_lat,
  input  logic [IDX_W-1:0]  dest_idx,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              lat_err,
  output logic              run_done
);
  import wbq_pkg::*;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  step_kind_e        kind;
  logic              is_end, is_op, consume, lat_ok, ins_en, do_write;
  logic [PW-1:0]     head, ins_idx;
  logic [DATA_W-1:0] head_data;

  assign kind     = step_kind_e'(step_kind);
  assign is_end   = step_valid && (kind == STEP_END);
  assign is_op    = step_valid && (kind == STEP_OP);
  assign consume  = step_valid && (kind != STEP_END);
  assign ins_en   = is_op && lat_ok;
  assign do_write = consume && (dest_idx != '0);

  wbq_head_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .adv  (consume),
    .head (head)
  );

  wbq_lat_check #(.DEPTH(DEPTH), .LAT_W(LAT_W)) u_lat (
    .head    (head),
    .lat     (res_lat),
    .lat_ok  (lat_ok),
    .ins_idx (ins_idx)
  );

  wbq_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .consume   (consume),
    .head      (head),
    .ins_en    (ins_en),
    .ins_idx   (ins_idx),
    .ins_data  (res_data),
    .head_data (head_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_we    <= 1'b0;
      rf_waddr <= '0;
      rf_wdata <= '0;
      lat_err  <= 1'b0;
      run_done <= 1'b0;
    end else begin
      rf_we    <= do_write;
      lat_err  <= is_op && !lat_ok;
      run_done <= is_end;
      if (do_write) begin
        rf_waddr <= dest_idx;
        rf_wdata <= head_data;
      end
    end
  end

  // R3: register 0 is never the target of a write
  p_no_zero_addr_r3: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> rf_waddr != '0);

  // R7: an end-of-run step leaves the head where it was
  p_end_holds_head_r7: assert property (@(posedge clk) disable iff (rst)
    is_end |=> $stable(head));

  // R7: the end indication never comes with a write
  p_end_no_write_r7: assert property (@(posedge clk) disable iff (rst)
    run_done |-> !rf_we);

  // R8: a latency error only follows a compute step
  p_err_cause_r8: assert property (@(posedge clk) disable iff (rst)
    lat_err |-> $past(step_valid) && $past(step_kind) == 2'b00);

  // R10: an idle cycle raises no output
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !step_valid |=> !rf_we && !lat_err && !run_done);
endmodule

// File: tb/wbq_sched_test.sv
`timescale 1ns/1ps
module wbq_sched_test;
  localparam int DEPTH  = 7;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 7;
  localparam int LAT_W  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              step_valid = 1'b0;
  logic [1:0]        step_kind = 2'b00;
  logic [DATA_W-1:0] res_data = '0;
  logic [LAT_W-1:0]  res_lat = '0;
  logic [IDX_W-1:0]  dest_idx = '0;
  logic              rf_we, lat_err, run_done;
  logic [IDX_W-1:0]  rf_waddr;
  logic [DATA_W-1:0] rf_wdata;

  always #2.5 clk = ~clk;

  wbq_sched #(.DEPTH(DEPTH), .DATA_W(DATA_W), .IDX_W(IDX_W), .LAT_W(LAT_W)) uut (
    .clk(clk), .rst(rst), .step_valid(step_valid), .step_kind(step_kind),
    .res_data(res_data), .res_lat(res_lat), .dest_idx(dest_idx),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .lat_err(lat_err), .run_done(run_done));

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  string cur_tag = "R1";
  string exp_tag = "R1";

  // behavioural reference: a ring of pending results
  logic [DATA_W-1:0] ring [DEPTH];
  int                hd = 0;
  bit                e_we = 0, e_err = 0, e_done = 0;
  logic [IDX_W-1:0]  e_addr = '0;
  logic [DATA_W-1:0] e_data = '0;

  always @(posedge clk) begin
    exp_tag = cur_tag;
    e_we = 0; e_err = 0; e_done = 0;
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) ring[k] = '0;
      hd = 0;
    end else if (step_valid) begin
      if (step_kind == 2'b10) begin
        e_done = 1;
      end else begin
        if (dest_idx != 0) begin
          e_we = 1; e_addr = dest_idx; e_data = ring[hd];
        end
        ring[hd] = '0;
        hd = (hd + 1) % DEPTH;
        if (step_kind == 2'b00) begin
          if (res_lat >= 1 && int'(res_lat) <= DEPTH)
            ring[(hd + int'(res_lat) - 1) % DEPTH] = res_data;
          else
            e_err = 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (rf_we !== e_we || lat_err !== e_err || run_done !== e_done ||
          (e_we && (rf_waddr !== e_addr || rf_wdata !== e_data))) begin
        errors++;
        $display("FAIL %s: got we=%0b addr=%0d data=%08h err=%0b done=%0b, expected we=%0b addr=%0d data=%08h err=%0b done=%0b",
                 exp_tag, rf_we, rf_waddr, rf_wdata, lat_err, run_done,
                 e_we, e_addr, e_data, e_err, e_done);
      end
    end
  end

  task automatic step(input string tag, input logic [1:0] kind,
                      input logic [DATA_W-1:0] d, input int lat, input int dst);
    @(negedge clk);
    cur_tag    = tag;
    step_valid = 1'b1;
    step_kind  = kind;
    res_data   = d;
    res_lat    = LAT_W'(lat);
    dest_idx   = IDX_W'(dst);
  endtask

  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cur_tag = tag;
      step_valid = 1'b0;
      res_data = 32'hDEAD_BEEF;
      dest_idx = 7'd9;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 / R5: fresh queue writes zero
    step("R1", 2'b01, 0, 0, 4);
    // R4 latency 1, then read back next step
    step("R4", 2'b00, 32'h0000_0011, 1, 5);
    step("R4", 2'b01, 0, 0, 6);
    // R3: zero destination still consumes
    step("R3", 2'b00, 32'h0000_00A5, 3, 0);
    step("R3", 2'b00, 32'h0000_00B6, 2, 0);
    step("R6", 2'b01, 0, 0, 1);
    step("R4", 2'b11, 0, 0, 2);
    step("R4", 2'b01, 0, 0, 3);
    step("R5", 2'b01, 0, 0, 3);
    // R7: end step freezes the queue in the middle of a pending result
    step("R7", 2'b00, 32'h0000_0C0C, 2, 0);
    step("R7", 2'b10, 32'hFFFF_FFFF, 1, 8);
    step("R7", 2'b10, 0, 0, 8);
    step("R7", 2'b01, 0, 0, 10);
    step("R7", 2'b01, 0, 0, 11);
    // R8: bad latencies
    step("R8", 2'b00, 32'h1234_5678, 0, 12);
    step("R8", 2'b00, 32'h8765_4321, 9, 13);
    step("R8", 2'b00, 32'h0BAD_0BAD, 15, 14);
    for (int k = 0; k < DEPTH; k++) step("R8", 2'b01, 0, 0, 20 + k);
    // R9: latency equal to depth
    step("R9", 2'b00, 32'h7777_0007, 7, 30);
    for (int k = 0; k < DEPTH; k++) step("R9", 2'b01, 0, 0, 31 + k);
    // R10: idle gaps do not disturb a pending result
    step("R10", 2'b00, 32'h0000_1010, 3, 0);
    idle("R10", 4);
    step("R10", 2'b01, 0, 0, 40);
    idle("R10", 2);
    step("R10", 2'b01, 0, 0, 41);
    step("R10", 2'b01, 0, 0, 42);
    // R2 / R4: mixed pseudo-random stream
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 300; n++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      if (lf[3:0] == 4'd0) idle("R10", 1);
      else begin
        logic [1:0] kk;
        int lt;
        kk = (lf[7:4] < 4'd10) ? 2'b00 : (lf[7:4] < 4'd13) ? 2'b01 :
             (lf[7:4] < 4'd15) ? 2'b11 : 2'b10;
        lt = (lf[11:8] == 4'd0) ? int'(lf[15:12]) : 1 + int'(lf[14:12]) % DEPTH;
        step("R2", kk, lf ^ 32'h5A5A_0000, lt, int'(lf[22:16]) & ((lf[23]) ? 0 : 127));
      end
    end
    idle("R10", 3);
    // R1: reset in flight returns the queue to empty
    step("R1", 2'b00, 32'hCAFE_0001, 2, 0);
    @(negedge clk); step_valid = 1'b0; rst = 1'b1; cur_tag = "R1";
    @(negedge clk); rst = 1'b0;
    step("R1", 2'b01, 0, 0, 50);
    step("R1", 2'b01, 0, 0, 51);
    idle("R1", 2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule